// File: doc/BRIEF.md
# CCD Vertical Readout Sequencer

This block drives the vertical side of a three-field interline CCD. It counts line strobes inside each frame strobe and decides, line by line, whether the line is transferred out and which field group it belongs to. In preview operation it produces a decimated line pattern. An optional window sub-mode keeps only a band of rows and marks the rest for high-speed sweep. The full-resolution still picture is read as three interleaved frames.

A capture request starts a still sequence with these steps. The substrate-bias control is raised and held for a lead time counted in line periods. An electronic-shutter burst marks the start of exposure, and the exposure runs a fixed number of lines. The vertical register is then swept for a number of whole frames. After that come the three field readouts, and the block returns to preview. Lines read while the substrate bias is raised carry blooming, so they are not flagged valid.

Top module: `ccd_vseq`

## Requirements
- R1: While reset is asserted and right after it, `rd_en_o`, `shut_o`, `bias_o`, `sweep_o` and `line_ok_o` are all low and the block is in preview.
- R2: In the full-resolution frame for field group k (0, 1, 2), a line n with n < LINES is read when (n/2) mod 3 equals k. The read shows as a one-cycle pulse on `rd_en_o[k]`, one clock after the line strobe. Lines at or beyond LINES are never read.
- R3: After the sweep frames, the readout frames run in the order group 0, group 1, group 2, each starting on a frame strobe. The frame strobe that ends group 2 returns the block to preview.
- R4: In preview with the window off, line n < LINES is read on `rd_en_o[0]` when (n/2) mod 6 equals 0, and on `rd_en_o[1]` when it equals 3. That is 4 lines out of every 12.
- R5: In preview with `win_mode_i` high, only lines with WIN_TOP <= n < WIN_BOT keep the R4 pattern. Every other line gives no read and holds `sweep_o` high for that line.
- R6: A capture produces exactly SHUT_N shutter pulses on `shut_o`, one per line strobe, always while `bias_o` is high.
- R7: `bias_o` rises the cycle after an accepted request. The burst begins only at the first frame strobe by which at least LEAD_LINES line strobes have been counted since the rise; otherwise one more frame is waited.
- R8: The frame strobe after exposure ends starts SWEEP_N whole frames with `sweep_o` high and no reads.
- R9: `line_ok_o` pulses together with a read only if `bias_o` was low when that line started.
- R10: A capture request while a capture is already running has no effect.
- R11: Exposure lasts EXP_LINES line strobes after the last shutter pulse's line. `bias_o` falls on the final one, and no lines are read until the sweep begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hd_i | input | 1 | One-cycle line-start strobe |
| vd_i | input | 1 | One-cycle frame-start strobe |
| win_mode_i | input | 1 | Preview window sub-mode select |
| cap_req_i | input | 1 | Still-capture request strobe |
| rd_en_o | output | 3 | Per-field-group read pulse |
| shut_o | output | 1 | Electronic-shutter pulse |
| bias_o | output | 1 | Substrate-bias control level |
| sweep_o | output | 1 | High-speed sweep active |
| line_ok_o | output | 1 | Read line carries valid picture data |

## Verification
The hardest point to reach is a capture request that arrives so late in a frame that the lead time cannot be met. The sequencer must then stay in its bias phase through one extra frame strobe with no shutter pulse. The bench builds the block with a short frame and a short lead. It raises the request four lines before the frame ends, so exactly one frame strobe must be skipped. It then follows the whole capture chain frame by frame into the three readouts and back to preview.

// File: rtl/ccd_vseq_pkg.sv
package ccd_vseq_pkg;

  typedef enum logic [3:0] {
    ST_LIVE,
    ST_LEAD,
    ST_BURST,
    ST_EXPOSE,
    ST_CLOSED,
    ST_SWEEP,
    ST_RD_A,
    ST_RD_B,
    ST_RD_C
  } seq_st_e;

  function automatic logic is_preview(seq_st_e s);
    return s inside {ST_LIVE, ST_LEAD, ST_BURST, ST_EXPOSE};
  endfunction

  function automatic logic is_biased(seq_st_e s);
    return s inside {ST_LEAD, ST_BURST, ST_EXPOSE};
  endfunction

endpackage

// File: rtl/vseq_linecnt.sv
module vseq_linecnt #(
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hd,
  input  logic          vd,
  output logic [LW-1:0] line_idx
);

  logic [LW-1:0] idx_d;

  always_comb begin
    idx_d = line_idx;
    if (vd)
      idx_d = '0;
    else if (hd && !(&line_idx))
      idx_d = line_idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      line_idx <= '0;
    else if (vd || hd)
      line_idx <= idx_d;
  end

endmodule

// File: rtl/vseq_ctrl.sv
module vseq_ctrl
  import ccd_vseq_pkg::*;
#(
  parameter int LEAD_LINES = 266,
  parameter int SHUT_N     = 20,
  parameter int EXP_LINES  = 300,
  parameter int SWEEP_N    = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    hd,
  input  logic    vd,
  input  logic    cap_req,
  output seq_st_e st
);

  localparam int M1   = (LEAD_LINES > SHUT_N) ? LEAD_LINES : SHUT_N;
  localparam int M2   = (EXP_LINES > SWEEP_N) ? EXP_LINES : SWEEP_N;
  localparam int CMAX = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] LEAD_C  = CW'(LEAD_LINES);
  localparam logic [CW-1:0] SHUT_C  = CW'(SHUT_N - 1);
  localparam logic [CW-1:0] EXP_C   = CW'(EXP_LINES - 1);
  localparam logic [CW-1:0] SWEEP_C = CW'(SWEEP_N - 1);

  seq_st_e       st_d;
  logic [CW-1:0] cnt, cnt_d;

  always_comb begin
    st_d  = st;
    cnt_d = cnt;
    unique case (st)
      ST_LIVE: if (cap_req) begin
        st_d  = ST_LEAD;
        cnt_d = '0;
      end
      ST_LEAD: begin
        if (vd) begin
          if (cnt >= LEAD_C) begin
            st_d  = ST_BURST;
            cnt_d = '0;
          end
        end else if (hd && cnt < LEAD_C) begin
          cnt_d = cnt + 1'b1;
        end
      end
      ST_BURST: if (hd) begin
        if (cnt == SHUT_C) begin
          st_d  = ST_EXPOSE;
          cnt_d = '0;
        end else cnt_d = cnt + 1'b1;
      end
      ST_EXPOSE: if (hd) begin
        if (cnt == EXP_C) begin
          st_d  = ST_CLOSED;
          cnt_d = '0;
        end else cnt_d = cnt + 1'b1;
      end
      ST_CLOSED: if (vd) begin
        st_d  = ST_SWEEP;
        cnt_d = '0;
      end
      ST_SWEEP: if (vd) begin
        if (cnt == SWEEP_C) begin
          st_d  = ST_RD_A;
          cnt_d = '0;
        end else cnt_d = cnt + 1'b1;
      end
      ST_RD_A: if (vd) st_d = ST_RD_B;
      ST_RD_B: if (vd) st_d = ST_RD_C;
      ST_RD_C: if (vd) st_d = ST_LIVE;
      default: st_d = ST_LIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_LIVE;
      cnt <= '0;
    end else begin
      st  <= st_d;
      cnt <= cnt_d;
    end
  end

endmodule

// File: rtl/vseq_select.sv
module vseq_select
  import ccd_vseq_pkg::*;
#(
  parameter int LINES   = 1550,
  parameter int WIN_TOP = 486,
  parameter int WIN_BOT = 1062,
  parameter int LW      = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hd,
  input  logic          vd,
  input  logic          win_mode,
  input  seq_st_e       st,
  input  logic [LW-1:0] line_idx,
  output logic [2:0]    rd_en,
  output logic          line_ok,
  output logic          win_sweep,
  output logic          shut
);

  localparam logic [LW-1:0] LINES_C = LW'(LINES);
  localparam logic [LW-1:0] TOP_C   = LW'(WIN_TOP);
  localparam logic [LW-1:0] BOT_C   = LW'(WIN_BOT);
  localparam logic [LW-1:0] SIX     = LW'(6);
  localparam logic [LW-1:0] THREE   = LW'(3);

  logic [LW-1:0] pair, m6, m3;
  logic          in_rng, in_win, preview;
  logic [2:0]    fast_sel, sel;

  always_comb begin
    pair     = line_idx >> 1;
    m6       = pair % SIX;
    m3       = pair % THREE;
    in_rng   = line_idx < LINES_C;
    in_win   = (line_idx >= TOP_C) && (line_idx < BOT_C);
    preview  = is_preview(st);
    fast_sel = {1'b0, m6 == LW'(3), m6 == LW'(0)};
    sel      = 3'b000;
    if (in_rng) begin
      unique case (st)
        ST_RD_A: sel = (m3 == LW'(0)) ? 3'b001 : 3'b000;
        ST_RD_B: sel = (m3 == LW'(1)) ? 3'b010 : 3'b000;
        ST_RD_C: sel = (m3 == LW'(2)) ? 3'b100 : 3'b000;
        default: sel = (preview && (!win_mode || in_win)) ? fast_sel : 3'b000;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_en     <= 3'b000;
      line_ok   <= 1'b0;
      shut      <= 1'b0;
      win_sweep <= 1'b0;
    end else begin
      rd_en   <= hd ? sel : 3'b000;
      line_ok <= hd && (|sel) && !is_biased(st);
      shut    <= hd && (st == ST_BURST);
      if (vd)
        win_sweep <= 1'b0;
      else if (hd)
        win_sweep <= preview && win_mode && !in_win;
    end
  end

  // R2
  rd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_en));

  // R9
  ok_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_ok |-> (rd_en != 3'b000));

endmodule

// File: rtl/ccd_vseq.sv
module ccd_vseq
  import ccd_vseq_pkg::*;
#(
  parameter int LINES     = 1550,
  parameter int WIN_TOP   = 486,
  parameter int WIN_BOT   = 1062,
  parameter int LINE_NS   = 113_000,
  parameter int SHUT_N    = 20,
  parameter int EXP_LINES = 300,
  parameter int SWEEP_N   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hd_i,
  input  logic       vd_i,
  input  logic       win_mode_i,
  input  logic       cap_req_i,
  output logic [2:0] rd_en_o,
  output logic       shut_o,
  output logic       bias_o,
  output logic       sweep_o,
  output logic       line_ok_o
);

  localparam int LW         = $clog2(LINES) + 1;
  localparam int LEAD_LINES = (30_000_000 + LINE_NS - 1) / LINE_NS;
  localparam int CKW        = $clog2(LEAD_LINES + SHUT_N + 1) + 1;

  seq_st_e       st;
  logic [LW-1:0] line_idx;
  logic          win_sweep;

  vseq_linecnt #(.LW(LW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .hd(hd_i), .vd(vd_i), .line_idx(line_idx)
  );

  vseq_ctrl #(
    .LEAD_LINES(LEAD_LINES), .SHUT_N(SHUT_N),
    .EXP_LINES(EXP_LINES),   .SWEEP_N(SWEEP_N)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .hd(hd_i), .vd(vd_i),
    .cap_req(cap_req_i), .st(st)
  );

  vseq_select #(
    .LINES(LINES), .WIN_TOP(WIN_TOP), .WIN_BOT(WIN_BOT), .LW(LW)
  ) u_sel (
    .clk(clk), .rst_n(rst_n), .hd(hd_i), .vd(vd_i),
    .win_mode(win_mode_i), .st(st), .line_idx(line_idx),
    .rd_en(rd_en_o), .line_ok(line_ok_o), .win_sweep(win_sweep),
    .shut(shut_o)
  );

  assign bias_o  = is_biased(st);
  assign sweep_o = (st == ST_SWEEP) || win_sweep;

  // checker bookkeeping: line strobes before the first pulse, pulses per capture
  logic [CKW-1:0] lead_hd, shut_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_hd   <= '0;
      shut_seen <= '0;
    end else if (!bias_o) begin
      lead_hd   <= '0;
      shut_seen <= '0;
    end else begin
      if (hd_i && shut_seen == '0 && !(&lead_hd))
        lead_hd <= lead_hd + 1'b1;
      if (shut_o && !(&shut_seen))
        shut_seen <= shut_seen + 1'b1;
    end
  end

  // R6
  shut_bias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shut_o |-> bias_o);

  // R6
  burst_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bias_o) |-> (shut_seen >= CKW'(SHUT_N)));

  // R7
  lead_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shut_o && shut_seen == '0) |-> (lead_hd >= CKW'(LEAD_LINES)));

  // R9
  ok_bias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_ok_o |-> !$past(bias_o));

  // R5
  sweep_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_o |-> (rd_en_o == 3'b000));

endmodule

// File: tb/ccd_vseq_tb.sv
module ccd_vseq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LINES      = 48;
  localparam int WTOP       = 12;
  localparam int WBOT       = 36;
  localparam int NHD        = 50;
  localparam int SHUTN      = 20;
  localparam int EXPL       = 5;

  localparam int K_FAST  = 0;
  localparam int K_WIN   = 1;
  localparam int K_SWEEP = 2;
  localparam int K_RDA   = 3;
  localparam int K_RDB   = 4;
  localparam int K_RDC   = 5;

  logic clk = 1'b0;
  logic rst_n, hd, vd, win_mode, cap_req;
  logic [2:0] rd_en;
  logic shut, bias, sweep, line_ok;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccd_vseq #(
    .LINES(LINES), .WIN_TOP(WTOP), .WIN_BOT(WBOT), .LINE_NS(3_000_000),
    .SHUT_N(SHUTN), .EXP_LINES(EXPL), .SWEEP_N(2)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .hd_i(hd), .vd_i(vd), .win_mode_i(win_mode),
    .cap_req_i(cap_req), .rd_en_o(rd_en), .shut_o(shut), .bias_o(bias),
    .sweep_o(sweep), .line_ok_o(line_ok)
  );

  task automatic chk(input bit good, input string req, input int act, input int exp);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int fast_exp(input int n);
    if (n >= LINES) return 0;
    if ((n/2) % 6 == 0) return 1;
    if ((n/2) % 6 == 3) return 2;
    return 0;
  endfunction

  function automatic int exp_rd(input int kind, input int n);
    case (kind)
      K_FAST: return fast_exp(n);
      K_WIN:  return (n >= WTOP && n < WBOT) ? fast_exp(n) : 0;
      K_RDA, K_RDB, K_RDC:
        return (n < LINES && (n/2) % 3 == kind - K_RDA) ? (1 << (kind - K_RDA)) : 0;
      default: return 0;
    endcase
  endfunction

  task automatic pulse_vd();
    @(negedge clk) vd = 1'b1;
    @(negedge clk) vd = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_line();
    @(negedge clk) hd = 1'b1;
    @(negedge clk) hd = 1'b0;
  endtask

  // one frame: vd then NHD lines; optional request after line req_at
  task automatic run_frame(input int kind, input bit bias_in, input int req_at,
                           input bit req_takes, input string tag, output int reads);
    bit b;
    int e;
    reads = 0;
    b = bias_in;
    pulse_vd();
    for (int n = 0; n < NHD; n++) begin
      do_line();
      e = exp_rd(kind, n);
      if (rd_en != 3'b000) reads++;
      chk(rd_en == 3'(e), tag, int'(rd_en), e);
      chk(line_ok == ((e != 0) && !b), {tag, " R9 line_ok"}, int'(line_ok), int'((e != 0) && !b));
      chk(bias == b, {tag, " bias"}, int'(bias), int'(b));
      chk(shut == 1'b0, {tag, " shut idle"}, int'(shut), 0);
      e = (kind == K_SWEEP) ? 1 : (kind == K_WIN && !(n >= WTOP && n < WBOT)) ? 1 : 0;
      chk(sweep == e[0], {tag, " sweep"}, int'(sweep), e);
      if (n == req_at) begin
        cap_req = 1'b1;
        @(negedge clk) cap_req = 1'b0;
        if (req_takes) b = 1'b1;
      end else begin
        @(negedge clk);
      end
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; hd = 1'b0; vd = 1'b0; win_mode = 1'b0; cap_req = 1'b0;
    repeat (3) @(negedge clk);
    chk({rd_en, shut, bias, sweep, line_ok} == 7'd0, "R1 in reset",
        int'({rd_en, shut, bias, sweep, line_ok}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({rd_en, shut, bias, sweep, line_ok} == 7'd0, "R1 after reset",
        int'({rd_en, shut, bias, sweep, line_ok}), 0);
  endtask

  task automatic t_fast();
    int r;
    win_mode = 1'b0;
    run_frame(K_FAST, 1'b0, -1, 1'b0, "R4 fast", r);
    chk(r == 16, "R4 four of twelve", r, 16);
  endtask

  task automatic t_window();
    int r;
    win_mode = 1'b1;
    run_frame(K_WIN, 1'b0, -1, 1'b0, "R5 window", r);
    chk(r == 8, "R5 window read count", r, 8);
    win_mode = 1'b0;
  endtask

  task automatic t_late_request();
    int r;
    run_frame(K_FAST, 1'b0, 45, 1'b1, "R7 late request", r);
    // lead not met at this strobe: one extra frame, still no shutter
    run_frame(K_FAST, 1'b1, -1, 1'b0, "R7 extra lead frame", r);
  endtask

  task automatic t_burst_expose();
    int pulses = 0;
    int e;
    pulse_vd();
    for (int n = 0; n < NHD; n++) begin
      do_line();
      if (shut) pulses++;
      if (n < SHUTN) begin
        chk(shut == 1'b1, "R6 burst pulse", int'(shut), 1);
        chk(bias == 1'b1, "R6 bias in burst", int'(bias), 1);
      end else if (n < SHUTN + EXPL - 1) begin
        chk(shut == 1'b0, "R11 exposure no pulse", int'(shut), 0);
        chk(bias == 1'b1, "R11 bias in exposure", int'(bias), 1);
      end else begin
        chk(bias == 1'b0, "R11 bias fell", int'(bias), 0);
      end
      e = (n < SHUTN + EXPL) ? fast_exp(n) : 0;
      chk(rd_en == 3'(e), "R11 reads", int'(rd_en), e);
      chk(line_ok == 1'b0, "R9 no valid under bias", int'(line_ok), 0);
      chk(sweep == 1'b0, "R8 no sweep yet", int'(sweep), 0);
      repeat (2) @(negedge clk);
    end
    chk(pulses == SHUTN, "R6 pulse count", pulses, SHUTN);
  endtask

  task automatic t_sweep_and_read();
    int r;
    run_frame(K_SWEEP, 1'b0, -1, 1'b0, "R8 sweep frame 1", r);
    run_frame(K_SWEEP, 1'b0, -1, 1'b0, "R8 sweep frame 2", r);
    run_frame(K_RDA, 1'b0, -1, 1'b0, "R2 R3 field A", r);
    chk(r == 16, "R2 field A lines", r, 16);
    run_frame(K_RDB, 1'b0, 10, 1'b0, "R3 R10 field B", r);
    chk(r == 16, "R2 field B lines", r, 16);
    run_frame(K_RDC, 1'b0, -1, 1'b0, "R3 field C", r);
    chk(r == 16, "R2 field C lines", r, 16);
    run_frame(K_FAST, 1'b0, -1, 1'b0, "R3 back to preview", r);
    run_frame(K_FAST, 1'b0, -1, 1'b0, "R10 no pending capture", r);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_fast();
    t_window();
    t_late_request();
    t_burst_expose();
    t_sweep_and_read();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule